// File: doc/BRIEF.md
# Variable-Length Instruction Operand Fetcher

This block turns an instruction pointer into a decoded instruction record. A one-cycle start pulse carries the pointer. The block then reads the instruction one byte at a time from a byte-wide memory that has one cycle of read latency. It classifies the leading opcode byte with an internal class table. That table gives the kind of each of up to two operands. The block then fetches each operand with the number of bytes its kind calls for.

Two-byte fields are assembled with the high byte at the lower address. A register-plus-offset operand is turned into an effective address while it is being fetched. The block does this through a combinational register read port: it adds the sign-extended offset byte to the value of the selected 16-bit register.

When the record is complete, the block pulses `done_o` for one cycle. The record holds the opcode, both operand kinds, the register indices, the resolved values, the instruction length and the next instruction pointer. An unknown opcode or an out-of-range register index pulses `illegal_o` instead of `done_o`.

Top module: `ofe_fetch`

## Requirements
- R1: After reset, `done_o`, `illegal_o` and `mem_rd_o` are low, and every record output reads zero.
- R2: The opcode is read from address `ip_i`. Each later byte is read from the next address, one byte per access. The memory address is the byte pointer taken modulo MEM_BYTES (default 1024).
- R3: The operand kinds use these codes: 0 none, 1 8-bit immediate, 2 16-bit immediate, 3 direct address, 4 8-bit register, 5 16-bit register, 6 register plus offset. Kinds 1, 4 and 5 take one byte. Kinds 2, 3 and 6 take two bytes. `len_o` is 1 plus the operand bytes, and `next_ip_o` is `ip + len_o` in 16 bits, without wrapping.
- R4: Two-byte immediates and addresses are big-endian: the byte at the lower address is the high byte.
- R5: A register-plus-offset operand has the base register index (0..4) in its first byte and a two's-complement offset in its second byte. Its value is the base register value plus the sign-extended offset, modulo 2^16. The base index is driven on `rd_idx_o` while the offset byte is captured.
- R6: A 16-bit register index must be 0..4 and an 8-bit register index must be 9..16. A violation in any register byte, including the base byte of kind 6, pulses `illegal_o` for one cycle, ends the fetch at that byte and gives no `done_o`.
- R7: An opcode with no class entry pulses `illegal_o` right after its byte is read, and no operand byte is fetched. Opcode 0xFF is such a case. Every opcode above 142 is unassigned.
- R8: `done_o` is a one-cycle pulse. The record stays unchanged until the next accepted start. A start that arrives while a fetch is in progress is ignored.
- R9: The class table includes these entries:
  - 0x00: no operands.
  - 0x07: kinds (6, 2).
  - 0x08: kinds (3, 2).
  - 0x0E: kinds (4, 1).
  - 0x11: kinds (5, 5).
  - 0x43: kinds (5, 0).
  - 0x45: kinds (6, 0).
  - 0x46: kinds (2, 0).
  An absent first operand implies an absent second one.
- R10: Per operand, `regN_o` is the register index for kinds 4 and 5, the base index for kind 6, and 0 otherwise. `valN_o` is the immediate or address for kinds 1 to 3, the effective address for kind 6, and 0 otherwise. An 8-bit immediate is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a fetch at `ip_i` (ignored while busy) |
| ip_i | input | 16 | Instruction pointer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 10 | Memory byte address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the strobe |
| rd_idx_o | output | 3 | Register read index for offset resolution |
| rd_val_i | input | 16 | Register read value (combinational) |
| done_o | output | 1 | Record valid pulse |
| illegal_o | output | 1 | Illegal instruction pulse |
| opcode_o | output | 8 | Opcode |
| kind1_o | output | 3 | First operand kind |
| kind2_o | output | 3 | Second operand kind |
| reg1_o | output | 5 | First operand register index |
| reg2_o | output | 5 | Second operand register index |
| val1_o | output | 16 | First operand value or effective address |
| val2_o | output | 16 | Second operand value or effective address |
| len_o | output | 3 | Instruction length in bytes |
| next_ip_o | output | 16 | Pointer to the following instruction |

## Verification
The bench aims at the places where a field-length or byte-order slip shows up.

- A register-plus-offset operand followed by a word immediate. A design that gave the wrong length to either field would misplace the immediate and report the wrong length.
- A negative offset, and a positive offset that carries past 0xFFFF. A design that zero-extended the offset would give an address 256 too high.
- An instruction that straddles the top of memory. A design that did not wrap the address would read the wrong bytes.
- Register indices just outside each legal set (5, 8, 9 as a base), the 8-bit boundary index 16, and a start pulse sent mid-fetch. A design that restarted on that pulse would return a second, wrong record.

// File: rtl/ofe_pkg.sv
package ofe_pkg;
  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_IMM8   = 3'd1,
    K_IMM16  = 3'd2,
    K_ADDR   = 3'd3,
    K_REG8   = 3'd4,
    K_REG16  = 3'd5,
    K_REGOFF = 3'd6
  } kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_CAP} st_e;
  typedef enum logic [1:0] {PH_OP, PH_F1, PH_F2} ph_e;

  // Group bases: register first operand, then a 4-entry second-operand set
  localparam int N_W2 = 8;
  localparam int N_B2 = 8;
  localparam int N_W1 = 5;
  localparam int N_B1 = 3;
  localparam logic [7:0] GRP_W2 [N_W2] = '{8'd17, 8'd25, 8'd37, 8'd88, 8'd96, 8'd104, 8'd114, 8'd122};
  localparam logic [7:0] GRP_B2 [N_B2] = '{8'd21, 8'd29, 8'd41, 8'd92, 8'd100, 8'd108, 8'd118, 8'd126};
  // Group bases: single operand drawn from the 4-entry set
  localparam logic [7:0] GRP_W1 [N_W1] = '{8'd59, 8'd72, 8'd80, 8'd135, 8'd139};
  localparam logic [7:0] GRP_B1 [N_B1] = '{8'd63, 8'd76, 8'd84};

  // Slot order within a group: register, reg+offset, address, immediate
  function automatic kind_e grp_kind(input logic [1:0] slot, input logic wide);
    case (slot)
      2'd0:    grp_kind = wide ? K_REG16 : K_REG8;
      2'd1:    grp_kind = K_REGOFF;
      2'd2:    grp_kind = K_ADDR;
      default: grp_kind = wide ? K_IMM16 : K_IMM8;
    endcase
  endfunction

  function automatic logic is_wide(input kind_e k);
    is_wide = (k == K_IMM16) || (k == K_ADDR) || (k == K_REGOFF);
  endfunction
endpackage

// File: rtl/ofe_class.sv
module ofe_class
  import ofe_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       legal_o,
  output kind_e      k1_o,
  output kind_e      k2_o
);
  logic       wide;
  logic [7:0] d;
  kind_e      rk, ik;

  always_comb begin
    legal_o = 1'b0;
    k1_o    = K_NONE;
    k2_o    = K_NONE;
    d       = 8'd0;
    wide    = (op_i <= 8'd8);
    rk      = wide ? K_REG16 : K_REG8;
    ik      = wide ? K_IMM16 : K_IMM8;

    if (op_i == 8'd0 || op_i == 8'd71 || (op_i >= 8'd130 && op_i <= 8'd134))
      legal_o = 1'b1;

    // copy forms: full destination/source matrix
    if (op_i >= 8'd1 && op_i <= 8'd16) begin
      legal_o = 1'b1;
      case (3'(op_i - 8'd1))
        3'd0: begin k1_o = rk;       k2_o = rk;       end
        3'd1: begin k1_o = rk;       k2_o = K_REGOFF; end
        3'd2: begin k1_o = rk;       k2_o = K_ADDR;   end
        3'd3: begin k1_o = K_REGOFF; k2_o = rk;       end
        3'd4: begin k1_o = K_ADDR;   k2_o = rk;       end
        3'd5: begin k1_o = rk;       k2_o = ik;       end
        3'd6: begin k1_o = K_REGOFF; k2_o = ik;       end
        default: begin k1_o = K_ADDR; k2_o = ik;      end
      endcase
    end

    if (op_i == 8'd33 || op_i == 8'd35 || op_i == 8'd67 || op_i == 8'd112) begin
      legal_o = 1'b1; k1_o = K_REG16;
    end
    if (op_i == 8'd34 || op_i == 8'd36 || op_i == 8'd68 || op_i == 8'd113) begin
      legal_o = 1'b1; k1_o = K_REG8;
    end

    // branches and calls: odd = reg+offset, even = word target
    if ((op_i >= 8'd45 && op_i <= 8'd58) || op_i == 8'd69 || op_i == 8'd70) begin
      legal_o = 1'b1;
      k1_o    = op_i[0] ? K_REGOFF : K_IMM16;
    end

    for (int i = 0; i < N_W2; i++) begin
      d = op_i - GRP_W2[i];
      if (d < 8'd4) begin legal_o = 1'b1; k1_o = K_REG16; k2_o = grp_kind(d[1:0], 1'b1); end
    end
    for (int i = 0; i < N_B2; i++) begin
      d = op_i - GRP_B2[i];
      if (d < 8'd4) begin legal_o = 1'b1; k1_o = K_REG8; k2_o = grp_kind(d[1:0], 1'b0); end
    end
    for (int i = 0; i < N_W1; i++) begin
      d = op_i - GRP_W1[i];
      if (d < 8'd4) begin legal_o = 1'b1; k1_o = grp_kind(d[1:0], 1'b1); end
    end
    for (int i = 0; i < N_B1; i++) begin
      d = op_i - GRP_B1[i];
      if (d < 8'd4) begin legal_o = 1'b1; k1_o = grp_kind(d[1:0], 1'b0); end
    end
  end
endmodule

// File: rtl/ofe_field.sv
module ofe_field
  import ofe_pkg::*;
#(
  parameter int XW = 16
) (
  input  kind_e         kind_i,
  input  logic          bsel_i,
  input  logic [7:0]    byte_i,
  input  logic [7:0]    hi_i,
  input  logic [XW-1:0] base_i,
  output logic          last_o,
  output logic          bad_o,
  output logic [4:0]    reg_o,
  output logic [XW-1:0] val_o
);
  logic [XW-1:0] off_sx;
  assign off_sx = {{(XW-8){byte_i[7]}}, byte_i};
  assign last_o = !is_wide(kind_i) || bsel_i;

  always_comb begin
    bad_o = 1'b0;
    reg_o = 5'd0;
    val_o = '0;
    case (kind_i)
      K_REG16: begin bad_o = (byte_i > 8'd4); reg_o = byte_i[4:0]; end
      K_REG8:  begin bad_o = (byte_i < 8'd9) || (byte_i > 8'd16); reg_o = byte_i[4:0]; end
      K_IMM8:  val_o = XW'(byte_i);
      K_IMM16, K_ADDR: val_o = XW'({hi_i, byte_i});
      K_REGOFF: begin
        bad_o = !bsel_i && (byte_i > 8'd4);
        reg_o = hi_i[4:0];
        val_o = base_i + off_sx;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ofe_fetch.sv
module ofe_fetch
  import ofe_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int XW        = 16,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [XW-1:0] ip_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [2:0]    rd_idx_o,
  input  logic [XW-1:0] rd_val_i,
  output logic          done_o,
  output logic          illegal_o,
  output logic [7:0]    opcode_o,
  output logic [2:0]    kind1_o,
  output logic [2:0]    kind2_o,
  output logic [4:0]    reg1_o,
  output logic [4:0]    reg2_o,
  output logic [XW-1:0] val1_o,
  output logic [XW-1:0] val2_o,
  output logic [2:0]    len_o,
  output logic [XW-1:0] next_ip_o
);
  st_e           st_q;
  ph_e           ph_q;
  logic          bsel_q;
  logic [7:0]    hi_q;
  logic [XW-1:0] addr_q, ip_q;
  logic [2:0]    cnt_q;
  kind_e         k1_q, k2_q;

  logic          legal;
  kind_e         ck1, ck2, cur_kind;
  logic          f_last, f_bad;
  logic [4:0]    f_reg;
  logic [XW-1:0] f_val;

  ofe_class u_class (
    .op_i    (mem_rdata_i),
    .legal_o (legal),
    .k1_o    (ck1),
    .k2_o    (ck2)
  );

  assign cur_kind = (ph_q == PH_F2) ? k2_q : k1_q;

  ofe_field #(.XW(XW)) u_field (
    .kind_i (cur_kind),
    .bsel_i (bsel_q),
    .byte_i (mem_rdata_i),
    .hi_i   (hi_q),
    .base_i (rd_val_i),
    .last_o (f_last),
    .bad_o  (f_bad),
    .reg_o  (f_reg),
    .val_o  (f_val)
  );

  assign mem_rd_o   = (st_q == ST_REQ);
  assign mem_addr_o = addr_q[AW-1:0];
  assign rd_idx_o   = hi_q[2:0];
  assign kind1_o    = k1_q;
  assign kind2_o    = k2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_OP;  bsel_q <= 1'b0;  hi_q <= 8'd0;
      addr_q <= '0;     ip_q <= '0;     cnt_q <= 3'd0;
      k1_q <= K_NONE;   k2_q <= K_NONE;
      done_o <= 1'b0;   illegal_o <= 1'b0;  opcode_o <= 8'd0;
      reg1_o <= 5'd0;   reg2_o <= 5'd0;     val1_o <= '0;  val2_o <= '0;
      len_o <= 3'd0;    next_ip_o <= '0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          ip_q <= ip_i;  addr_q <= ip_i;  cnt_q <= 3'd0;
          ph_q <= PH_OP; bsel_q <= 1'b0;
          reg1_o <= 5'd0; reg2_o <= 5'd0; val1_o <= '0; val2_o <= '0;
          st_q <= ST_REQ;
        end
        ST_REQ: st_q <= ST_CAP;
        ST_CAP: begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q + 3'd1;
          st_q   <= ST_REQ;
          if (ph_q == PH_OP) begin
            if (!legal) begin
              illegal_o <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              opcode_o <= mem_rdata_i;
              k1_q     <= ck1;
              k2_q     <= ck2;
              if (ck1 == K_NONE) begin
                done_o <= 1'b1; len_o <= cnt_q + 3'd1; next_ip_o <= addr_q + 1'b1;
                st_q   <= ST_IDLE;
              end else ph_q <= PH_F1;
            end
          end else if (f_bad) begin
            illegal_o <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (!f_last) begin
            hi_q   <= mem_rdata_i;
            bsel_q <= 1'b1;
          end else begin
            bsel_q <= 1'b0;
            if (ph_q == PH_F1) begin reg1_o <= f_reg; val1_o <= f_val; end
            else               begin reg2_o <= f_reg; val2_o <= f_val; end
            if (ph_q == PH_F1 && k2_q != K_NONE) ph_q <= PH_F2;
            else begin
              done_o <= 1'b1; len_o <= cnt_q + 3'd1; next_ip_o <= addr_q + 1'b1;
              st_q   <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_DONE_NOT_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));  // R6
  AST_LEN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= 3'd1 && len_o <= 3'd5));  // R3
  AST_NEXT_IP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (next_ip_o == ip_q + XW'(len_o)));  // R3
  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);  // R2
  AST_KIND_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && kind1_o == 3'd0) |-> (kind2_o == 3'd0));  // R9
endmodule

// File: tb/ofe_fetch_test.sv
module ofe_fetch_test;
  localparam int KN = 0, KI8 = 1, KI16 = 2, KAD = 3, KR8 = 4, KR16 = 5, KRO = 6;

  typedef struct {
    bit          ill;
    logic [7:0]  op;
    logic [2:0]  k1, k2;
    logic [4:0]  r1, r2;
    logic [15:0] v1, v2;
    logic [2:0]  len;
    logic [15:0] nip;
    string       req;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] ip = 16'd0;
  logic        mem_rd;
  logic [9:0]  mem_addr;
  logic [7:0]  rdata = 8'd0;
  logic [2:0]  rd_idx;
  logic [15:0] rd_val;
  logic        done, illegal;
  logic [7:0]  opcode;
  logic [2:0]  kind1, kind2, len;
  logic [4:0]  reg1, reg2;
  logic [15:0] val1, val2, next_ip;

  logic [7:0]  mem  [1024];
  logic [15:0] regs [5];
  exp_t        q[$];
  int          checks = 0, fails = 0;

  always #4 clk = ~clk;

  ofe_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ip_i(ip),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .rd_idx_o(rd_idx), .rd_val_i(rd_val),
    .done_o(done), .illegal_o(illegal), .opcode_o(opcode),
    .kind1_o(kind1), .kind2_o(kind2), .reg1_o(reg1), .reg2_o(reg2),
    .val1_o(val1), .val2_o(val2), .len_o(len), .next_ip_o(next_ip)
  );

  always @(posedge clk) if (mem_rd) rdata <= mem[mem_addr];
  assign rd_val = (rd_idx < 3'd5) ? regs[rd_idx] : 16'h0000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(bit ill, logic [7:0] op, int k1, int k2, logic [4:0] r1, logic [4:0] r2,
                              logic [15:0] v1, logic [15:0] v2, int ln, logic [15:0] nip, string req);
    exp_t e;
    e.ill = ill; e.op = op; e.k1 = 3'(k1); e.k2 = 3'(k2); e.r1 = r1; e.r2 = r2;
    e.v1 = v1; e.v2 = v2; e.len = 3'(ln); e.nip = nip; e.req = req;
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (done || illegal)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", {15'd0, done}, 16'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(illegal == e.ill, e.req, "illegal", {15'd0, illegal}, {15'd0, e.ill});
        chk(done == !e.ill, e.req, "done", {15'd0, done}, {15'd0, !e.ill});
        if (!e.ill && done) begin
          chk(opcode == e.op, e.req, "opcode", {8'd0, opcode}, {8'd0, e.op});
          chk(kind1 == e.k1 && kind2 == e.k2, e.req, "kinds", {10'd0, kind1, kind2}, {10'd0, e.k1, e.k2});
          chk(reg1 == e.r1, e.req, "reg1", {11'd0, reg1}, {11'd0, e.r1});
          chk(reg2 == e.r2, e.req, "reg2", {11'd0, reg2}, {11'd0, e.r2});
          chk(val1 == e.v1, e.req, "val1", val1, e.v1);
          chk(val2 == e.v2, e.req, "val2", val2, e.v2);
          chk(len == e.len, e.req, "len", {13'd0, len}, {13'd0, e.len});
          chk(next_ip == e.nip, e.req, "next_ip", next_ip, e.nip);
        end
      end
    end
  end

  task automatic launch(input logic [15:0] a, input exp_t e);
    @(negedge clk);
    start = 1'b1; ip = a; q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic poke(input int a, input logic [7:0] b);
    mem[a % 1024] = b;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    regs[0] = 16'h1111; regs[1] = 16'h2222; regs[2] = 16'h0100; regs[3] = 16'h4444; regs[4] = 16'hFFF0;
    poke(16'h010, 8'h11); poke(16'h011, 8'h01); poke(16'h012, 8'h03);
    poke(16'h020, 8'h07); poke(16'h021, 8'h02); poke(16'h022, 8'hFC); poke(16'h023, 8'h12); poke(16'h024, 8'h34);
    poke(16'h030, 8'h0E); poke(16'h031, 8'h0A); poke(16'h032, 8'h80);
    poke(16'h040, 8'h46); poke(16'h041, 8'hAB); poke(16'h042, 8'hCD);
    poke(16'h060, 8'h08); poke(16'h061, 8'h03); poke(16'h062, 8'hFF); poke(16'h063, 8'h00); poke(16'h064, 8'h05);
    poke(16'h070, 8'h45); poke(16'h071, 8'h04); poke(16'h072, 8'h7F);
    poke(16'h080, 8'hFF);
    poke(16'h090, 8'h43); poke(16'h091, 8'h05);
    poke(16'h0A0, 8'h0E); poke(16'h0A1, 8'h08); poke(16'h0A2, 8'h11);
    poke(16'h0B0, 8'h0E); poke(16'h0B1, 8'h10); poke(16'h0B2, 8'h00);
    poke(16'h0C0, 8'h45); poke(16'h0C1, 8'h09); poke(16'h0C2, 8'h00);
    poke(16'h3FE, 8'h46); poke(16'h3FF, 8'h12); poke(16'h000, 8'h34);
    // 0x050 holds 0x00: no-operand instruction

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !illegal && !mem_rd, "R1", "reset strobes", {13'd0, done, illegal, mem_rd}, 16'd0);
    chk(val1 == 0 && val2 == 0 && len == 0 && next_ip == 0 && opcode == 0, "R1", "reset record",
        val1 | val2 | next_ip, 16'd0);

    // R9 R3: two 16-bit registers
    launch(16'h010, mk(0, 8'h11, KR16, KR16, 5'd1, 5'd3, 16'h0, 16'h0, 3, 16'h0013, "R9"));
    // R5 R4 R3: negative offset then word immediate
    launch(16'h020, mk(0, 8'h07, KRO, KI16, 5'd2, 5'd0, 16'h00FC, 16'h1234, 5, 16'h0025, "R5"));
    // R10: 8-bit register then zero-extended byte
    launch(16'h030, mk(0, 8'h0E, KR8, KI8, 5'd10, 5'd0, 16'h0, 16'h0080, 3, 16'h0033, "R10"));
    // R4: big-endian word target
    launch(16'h040, mk(0, 8'h46, KI16, KN, 5'd0, 5'd0, 16'hABCD, 16'h0, 3, 16'h0043, "R4"));
    // R3: single-byte instruction
    launch(16'h050, mk(0, 8'h00, KN, KN, 5'd0, 5'd0, 16'h0, 16'h0, 1, 16'h0051, "R3"));
    // R3: address then word, five bytes
    launch(16'h060, mk(0, 8'h08, KAD, KI16, 5'd0, 5'd0, 16'h03FF, 16'h0005, 5, 16'h0065, "R3"));
    // R8: record held after done
    repeat (6) @(negedge clk);
    chk(val1 == 16'h03FF && val2 == 16'h0005 && opcode == 8'h08, "R8", "record held", val1, 16'h03FF);
    // R5: positive offset carrying past 0xFFFF
    launch(16'h070, mk(0, 8'h45, KRO, KN, 5'd4, 5'd0, 16'h006F, 16'h0, 3, 16'h0073, "R5"));
    // R7: unassigned opcode
    launch(16'h080, mk(1, 8'h0, KN, KN, 5'd0, 5'd0, 16'h0, 16'h0, 0, 16'h0, "R7"));
    // R6: bad 16-bit index, bad 8-bit index, bad base index
    launch(16'h090, mk(1, 8'h0, KN, KN, 5'd0, 5'd0, 16'h0, 16'h0, 0, 16'h0, "R6"));
    launch(16'h0A0, mk(1, 8'h0, KN, KN, 5'd0, 5'd0, 16'h0, 16'h0, 0, 16'h0, "R6"));
    launch(16'h0C0, mk(1, 8'h0, KN, KN, 5'd0, 5'd0, 16'h0, 16'h0, 0, 16'h0, "R6"));
    // R6: upper boundary index 16 accepted
    launch(16'h0B0, mk(0, 8'h0E, KR8, KI8, 5'd16, 5'd0, 16'h0, 16'h0, 3, 16'h00B3, "R6"));
    // R2: fetch straddles the end of memory
    launch(16'h03FE, mk(0, 8'h46, KI16, KN, 5'd0, 5'd0, 16'h1234, 16'h0, 3, 16'h0401, "R2"));

    // R8: start during a fetch is ignored
    @(negedge clk);
    start = 1'b1; ip = 16'h010;
    q.push_back(mk(0, 8'h11, KR16, KR16, 5'd1, 5'd3, 16'h0, 16'h0, 3, 16'h0013, "R8"));
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; ip = 16'h050;
    @(negedge clk); start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(opcode == 8'h11 && next_ip == 16'h0013, "R8", "busy start ignored", next_ip, 16'h0013);

    finish_run();
  end
endmodule